// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block is the general-purpose I/O unit of a small microcontroller. It holds five bidirectional 8-bit ports, each with a latched output value and a per-pin direction mask, plus one 8-bit port that can only be read. A byte-wide bus selects registers through an address, a write strobe and write data. Read data is combinational from the address. The block drives a per-pin output enable and output value toward the pads. It samples every input pin through a two-flop synchroniser.

The fourth bidirectional port, called port D here, has extra duties. Its pin 0 feeds a processor branch condition, and so does its pin 1 while the comparator is off. A change on any of its pins 2 to 5 gives a one-cycle interrupt pulse, whatever the pin's direction. While the comparator enable input is high, pins 4 and 5 are handed to the comparator, and their output enables are held low. A 16-bit general control register, written as two bytes, holds a single bit that switches on all eight pull-ups of the input-only port.

Top module: `gpio_bank`

## Requirements
- R1: Port k (k = 0..4, A..E) has its data register at address 8*k and its direction register at 8*k+4. A write with `bus_wr` high stores `bus_wdata` at the next rising clock edge. A read of a direction register returns its stored value.
- R2: A direction bit of 1 makes its pin an output: `pin_oe` is 1 and `pin_out` carries the data register bit. A direction bit of 0 gives `pin_oe` = 0. Pin j of port k sits at bit 8*k+j of the pin buses.
- R3: After reset, all data and direction registers read 0x00, every `pin_oe` bit is 0, `pullup_en_f` is 0 and no interrupt pulse is active.
- R4: A read of a data register returns the latched value for output bits and the synchronised pin value for input bits. A pin change shows up in the read data two rising edges after it is applied.
- R5: `cond1` follows synchronised port D pin 0. `cond2` follows synchronised port D pin 1 while `cmp_en` is 0, and it is 0 while `cmp_en` is 1.
- R6: While `cmp_en` is 1, the output enables of port D pins 4 and 5 are 0, whatever their direction bits hold.
- R7: A change on port D pin 2+i gives `pin_irq[i]` high for exactly one cycle, starting two rising edges after the change. This holds whether the pin is an input or an output. Changes on other pins give no pulse.
- R8: A read of address 0x28 returns the synchronised input-only port. Writes there have no effect.
- R9: The general control register is 16 bits, with the low byte at 0x38 and the high byte at 0x39. Both bytes read back. Bit 12 (bit 4 of the byte at 0x39) drives `pullup_en_f`. The register resets to 0.
- R10: Reads of unmapped addresses return 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 40 | Pad input values of ports A..E |
| pin_out | output | 40 | Pad output values of ports A..E |
| pin_oe | output | 40 | Pad output enables of ports A..E |
| pin_in_f | input | 8 | Input-only port pins |
| cmp_en | input | 1 | Comparator owns port D pins 4 and 5 |
| cond1 | output | 1 | Branch condition from port D pin 0 |
| cond2 | output | 1 | Branch condition from port D pin 1 |
| pin_irq | output | 4 | Change pulses for port D pins 2..5 |
| pullup_en_f | output | 1 | Pull-up enable for the input-only port |

## Verification
The single-pulse interrupt property assumes that a port D pin, once it changes, stays put for at least two clock cycles. A pin that toggles every cycle would give a correct pulse train that the property would flag. The bench drives pins only at falling edges and then waits several cycles before the next change, so it stays inside this assumption. The other properties assume only that bus inputs are stable at the rising edge. The bench meets this by driving the bus at falling edges.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W   = 8;
  localparam int GC_W     = 16;
  localparam int PU_BIT   = 12;
  localparam logic [ADDR_W-1:0] F_ADDR     = 8'h28;
  localparam logic [ADDR_W-1:0] GC_LO_ADDR = 8'h38;
  localparam logic [ADDR_W-1:0] GC_HI_ADDR = 8'h39;

  // address of the data register of port k
  function automatic logic [ADDR_W-1:0] data_addr(input int k);
    return ADDR_W'(k * 8);
  endfunction

  // address of the direction register of port k
  function automatic logic [ADDR_W-1:0] dir_addr(input int k);
    return ADDR_W'(k * 8 + 4);
  endfunction

  // read value: latched bits where output, pin bits where input
  function automatic logic [7:0] merge_read(input logic [7:0] dir,
                                            input logic [7:0] latch,
                                            input logic [7:0] pin);
    return (dir & latch) | (~dir & pin);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_data
);
  import gpio_bank_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  assign rd_data = merge_read(dir_q, data_q, pin_sync);

  assert_data_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(wdata));
  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  assert_dir_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] pulse
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign pulse = cur ^ prev_q;

  // assumes pins hold each level for at least two cycles
  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |=> !pulse[i]);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int PORT_W      = 8,
  parameter int NUM_PORTS   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int D_IDX       = 3,
  parameter int IRQ_LO      = 2,
  parameter int IRQ_N       = 4,
  parameter int CMP_LO      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [7:0]                    bus_addr,
  input  logic                          bus_wr,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
  output logic [PORT_W*NUM_PORTS-1:0]   pin_out,
  output logic [PORT_W*NUM_PORTS-1:0]   pin_oe,
  input  logic [PORT_W-1:0]             pin_in_f,
  input  logic                          cmp_en,
  output logic                          cond1,
  output logic                          cond2,
  output logic [IRQ_N-1:0]              pin_irq,
  output logic                          pullup_en_f
);
  import gpio_bank_pkg::*;

  localparam int ALL_W = PORT_W * NUM_PORTS;
  localparam int D_LSB = D_IDX * PORT_W;

  logic [ALL_W-1:0]  pin_sync;
  logic [PORT_W-1:0] f_sync;
  logic [ALL_W-1:0]  dir_all;
  logic [PORT_W-1:0] port_rd   [NUM_PORTS];
  logic [PORT_W-1:0] port_dir  [NUM_PORTS];
  logic [GC_W-1:0]   gc_q;
  logic              addr_hit;
  logic [PORT_W-1:0] d_sync;
  logic [ALL_W-1:0]  cmp_mask;

  gpio_sync #(.W(ALL_W), .STAGES(SYNC_STAGES)) u_sync_bidir (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync));

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_f (
    .clk(clk), .rst_n(rst_n), .d(pin_in_f), .q(f_sync));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    logic wr_d, wr_c;
    assign wr_d = bus_wr && (bus_addr == data_addr(k));
    assign wr_c = bus_wr && (bus_addr == dir_addr(k));
    gpio_port #(.W(PORT_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_data(wr_d), .wr_dir(wr_c), .wdata(bus_wdata),
      .pin_sync(pin_sync[k*PORT_W +: PORT_W]),
      .data_q(pin_out[k*PORT_W +: PORT_W]),
      .dir_q(port_dir[k]),
      .rd_data(port_rd[k]));
    assign dir_all[k*PORT_W +: PORT_W] = port_dir[k];
  end

  // comparator takes two port D pins away from the pad drivers
  always_comb begin
    cmp_mask = '1;
    if (cmp_en) begin
      cmp_mask[D_LSB + CMP_LO]     = 1'b0;
      cmp_mask[D_LSB + CMP_LO + 1] = 1'b0;
    end
  end
  assign pin_oe = dir_all & cmp_mask;

  assign d_sync = pin_sync[D_LSB +: PORT_W];
  assign cond1  = d_sync[0];
  assign cond2  = d_sync[1] & ~cmp_en;

  gpio_edge #(.W(IRQ_N)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .cur(d_sync[IRQ_LO +: IRQ_N]), .pulse(pin_irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gc_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == GC_LO_ADDR) gc_q[7:0]  <= bus_wdata;
      if (bus_addr == GC_HI_ADDR) gc_q[15:8] <= bus_wdata;
    end
  end
  assign pullup_en_f = gc_q[PU_BIT];

  always_comb begin
    bus_rdata = '0;
    addr_hit  = 1'b0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (bus_addr == data_addr(k)) begin
        bus_rdata = port_rd[k];
        addr_hit  = 1'b1;
      end
      if (bus_addr == dir_addr(k)) begin
        bus_rdata = port_dir[k];
        addr_hit  = 1'b1;
      end
    end
    if (bus_addr == F_ADDR) begin
      bus_rdata = f_sync;
      addr_hit  = 1'b1;
    end
    if (bus_addr == GC_LO_ADDR) begin
      bus_rdata = gc_q[7:0];
      addr_hit  = 1'b1;
    end
    if (bus_addr == GC_HI_ADDR) begin
      bus_rdata = gc_q[15:8];
      addr_hit  = 1'b1;
    end
  end

  assert_cmp_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> pin_oe[D_LSB + CMP_LO +: 2] == 2'b00);
  assert_cond2_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> !cond2);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> bus_rdata == '0);
  assert_pullup_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == GC_HI_ADDR) |=> $stable(pullup_en_f));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [39:0] pin_in = '0;
  logic [39:0] pin_out, pin_oe;
  logic [7:0]  pin_in_f = '0;
  logic        cmp_en = 1'b0;
  logic        cond1, cond2;
  logic [3:0]  pin_irq;
  logic        pullup_en_f;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in_f(pin_in_f),
    .cmp_en(cmp_en), .cond1(cond1), .cond2(cond2), .pin_irq(pin_irq),
    .pullup_en_f(pullup_en_f));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    bus_read(8'h04, r); check("R3 ctrl A", r, 8'h00);
    bus_read(8'h1C, r); check("R3 ctrl D", r, 8'h00);
    bus_read(8'h20, r); check("R3 data E", r, 8'h00);
    check("R3 oe", pin_oe, 40'h0);
    check("R3 pullup", pullup_en_f, 1'b0);
    check("R3 irq", pin_irq, 4'h0);
  endtask

  task automatic t_dir_and_read();
    logic [7:0] r;
    bus_write(8'h00, 8'hA5);
    bus_write(8'h04, 8'hF0);
    check("R2 oe A", pin_oe[7:0], 8'hF0);
    check("R2 out A", pin_out[7:0], 8'hA5);
    bus_read(8'h04, r); check("R1 ctrl A readback", r, 8'hF0);
    @(negedge clk); pin_in[7:0] = 8'h0F;
    wait_cyc(1);
    bus_read(8'h00, r); check("R4 mixed read A", r, 8'hAF);
    bus_write(8'h20, 8'h3C);
    bus_write(8'h24, 8'hFF);
    check("R2 oe E", pin_oe[39:32], 8'hFF);
    bus_read(8'h20, r); check("R4 all-output E", r, 8'h3C);
    bus_write(8'h0C, 8'h00);
    @(negedge clk); pin_in[15:8] = 8'h96;
    #1 bus_addr = 8'h08;
    @(negedge clk); #1 check("R4 read before sync", bus_rdata, 8'h00);
    @(negedge clk); #1 check("R4 read after sync", bus_rdata, 8'h96);
  endtask

  task automatic t_cond();
    @(negedge clk); pin_in[24] = 1'b1; pin_in[25] = 1'b1;
    wait_cyc(2);
    check("R5 cond1", cond1, 1'b1);
    check("R5 cond2 cmp off", cond2, 1'b1);
    cmp_en = 1'b1; #1;
    check("R5 cond2 cmp on", cond2, 1'b0);
    cmp_en = 1'b0;
    @(negedge clk); pin_in[24] = 1'b0;
    wait_cyc(2);
    check("R5 cond1 low", cond1, 1'b0);
  endtask

  task automatic t_cmp();
    bus_write(8'h1C, 8'hFF);
    check("R6 oe D cmp off", pin_oe[31:24], 8'hFF);
    cmp_en = 1'b1; #1;
    check("R6 oe D cmp on", pin_oe[31:24], 8'hCF);
    cmp_en = 1'b0; #1;
    check("R6 oe D restored", pin_oe[31:24], 8'hFF);
    bus_write(8'h1C, 8'h00);
  endtask

  task automatic t_irq();
    @(negedge clk); pin_in[26] = 1'b1;
    wait_cyc(1);
    check("R7 no pulse yet", pin_irq, 4'h0);
    wait_cyc(1);
    check("R7 pulse D2 input", pin_irq, 4'h1);
    wait_cyc(1);
    check("R7 pulse ends", pin_irq, 4'h0);
    bus_write(8'h1C, 8'h08);
    @(negedge clk); pin_in[27] = 1'b1;
    wait_cyc(2);
    check("R7 pulse D3 output", pin_irq, 4'h2);
    wait_cyc(3);
    @(negedge clk); pin_in[29] = 1'b1; pin_in[30] = 1'b1;
    wait_cyc(2);
    check("R7 pulse D5 only", pin_irq, 4'h8);
  endtask

  task automatic t_port_f();
    logic [7:0] r;
    @(negedge clk); pin_in_f = 8'h5A;
    wait_cyc(2);
    bus_read(8'h28, r); check("R8 F read", r, 8'h5A);
    bus_write(8'h28, 8'hFF);
    bus_read(8'h28, r); check("R8 F write ignored", r, 8'h5A);
  endtask

  task automatic t_gen_ctrl();
    logic [7:0] r;
    bus_write(8'h39, 8'h10);
    check("R9 pullup on", pullup_en_f, 1'b1);
    bus_write(8'h38, 8'hFF);
    check("R9 low byte no effect", pullup_en_f, 1'b1);
    bus_read(8'h38, r); check("R9 low readback", r, 8'hFF);
    bus_write(8'h39, 8'hEF);
    check("R9 pullup off", pullup_en_f, 1'b0);
    bus_read(8'h39, r); check("R9 high readback", r, 8'hEF);
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    bus_write(8'h30, 8'hFF);
    bus_write(8'h05, 8'h77);
    bus_read(8'h30, r); check("R10 read 0x30", r, 8'h00);
    bus_read(8'h05, r); check("R10 read 0x05", r, 8'h00);
    bus_read(8'h04, r); check("R10 ctrl A untouched", r, 8'hF0);
    bus_read(8'h00, r); check("R10 data A untouched", r, 8'hAF);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_dir_and_read();
    t_cond();
    t_cmp();
    t_irq();
    t_port_f();
    t_gen_ctrl();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule